// File: doc/BRIEF.md
# Banked nibble address generator

This block forms the 12-bit nibble address that a 4-bit processor presents to its data memory. It holds two 8-bit pointer pairs, a primary pair and a secondary pair, each made of a high and a low nibble. It also holds two 4-bit bank registers, a current bank and an extra bank. Each cycle a mode input picks the address source. The source is one of four: a full 12-bit field from the instruction word, the bottom page of the space (bank zero) with an 8-bit instruction field, the current bank with an 8-bit instruction field, or one bank register followed by one pointer pair.

An indirect access can step its pointer pair after the access. The step is applied when the operation-done strobe arrives. It adds one for nibble operations and two for byte-wide transfers. The access always uses the value the pair had before the step. A separate increment request adds one to a pair, as an increment instruction would. Every increment writes the overflow flag G, which records whether the pair wrapped past its top value. Load ports write the pairs and the bank registers. A load wins over an increment of the same pair in the same cycle.

Top module: `bank_nibble_agen`

## Requirements
- R1: After reset both pointer pairs, both bank registers and the G flag read zero.
- R2: With mode 0 (full direct), the address equals the 12-bit instruction field.
- R3: With mode 1 (bottom-page direct), address bits 11:8 are zero and bits 7:0 equal instruction bits 7:0.
- R4: With mode 2 (current-bank direct), address bits 11:8 equal the current bank register and bits 7:0 equal instruction bits 7:0.
- R5: With mode 3 (indirect), bits 11:8 come from the current bank (bank select 0) or the extra bank (bank select 1). Bits 7:0 come from the primary pair (pair select 0) or the secondary pair (pair select 1). The pair's high nibble is placed in bits 7:4.
- R6: In mode 3 with post-increment requested, the done strobe adds 1 to the selected pair, or 2 when the byte-wide input is high. The address in that cycle uses the old value, and the new value shows on the next cycle.
- R7: Each applied increment sets G to 1 when the pair passes 0xFF and wraps, and clears G to 0 otherwise.
- R8: The increment request adds 1 to the selected pair and updates G by the R7 rule.
- R9: The done strobe without post-increment requested, or outside mode 3, changes neither pair nor G.
- R10: A pair load in the same cycle as an increment of that pair stores the loaded value and leaves G unchanged.
- R11: Bank loads write the current or extra bank register, visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Address source: 0 full direct, 1 bottom page, 2 current bank, 3 indirect |
| ptr_sel_i | input | 1 | Pair used by indirect access and increments: 0 primary, 1 secondary |
| bank_sel_i | input | 1 | Bank used by indirect access: 0 current, 1 extra |
| post_inc_i | input | 1 | Indirect access asks for a post-increment |
| wide_i | input | 1 | Byte-wide transfer: the post-increment step is 2 |
| imm_i | input | 12 | Address field from the instruction word |
| op_done_i | input | 1 | Access complete: applies a pending post-increment |
| inc_req_i | input | 1 | Increment-by-one request on the selected pair |
| ld_ptr_i | input | 1 | Load a pointer pair |
| ld_ptr_sel_i | input | 1 | Pair to load: 0 primary, 1 secondary |
| ld_ptr_data_i | input | 8 | Pair load value |
| ld_cur_bank_i | input | 1 | Load the current bank register |
| ld_ext_bank_i | input | 1 | Load the extra bank register |
| ld_bank_data_i | input | 4 | Bank load value |
| addr_o | output | 12 | Data memory nibble address |
| pri_ptr_o | output | 8 | Primary pair value |
| sec_ptr_o | output | 8 | Secondary pair value |
| cur_bank_o | output | 4 | Current bank register |
| ext_bank_o | output | 4 | Extra bank register |
| g_flag_o | output | 1 | Pointer overflow flag |

## Verification
The address source is tried in all four modes with instruction fields whose upper nibble differs from the bank registers. This shows that bottom-page and current-bank modes really replace bits 11:8. The indirect mode is tried with all four bank and pair combinations, using distinct nibble values. This catches a swapped bank, a swapped pair or swapped nibbles. Step tests start from 0x13, 0xFE and 0xFF with steps of one and two. They separate a correct wrap from a missed carry, and a sweep of repeated two-steps walks a pair through several wraps. Strobes outside mode 3, strobes without post-increment, and loads that collide with increments show that G and the pairs are held exactly when they should be.

// File: rtl/bmag_pkg.sv
package bmag_pkg;
   typedef enum logic [1:0] {
      AM_DIRECT   = 2'd0,
      AM_BOTPAGE  = 2'd1,
      AM_CURBANK  = 2'd2,
      AM_INDIRECT = 2'd3
   } amode_e;
endpackage

// File: rtl/bmag_ptr_pair.sv
module bmag_ptr_pair #(
   parameter int PTR_W  = 8,
   parameter int STEP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_en_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic              ld_en_i,
   input  logic [PTR_W-1:0]  ld_data_i,
   output logic [PTR_W-1:0]  ptr_o,
   output logic              wrap_o
);
   localparam int SUM_W = PTR_W + 1;

   if (STEP_W >= SUM_W) begin : g_bad_step
      $error("step width must be narrower than pointer width plus one");
   end

   logic [PTR_W-1:0] ptr_q;
   logic [SUM_W-1:0] sum;

   always_comb begin
      sum    = {1'b0, ptr_q} + {{(SUM_W-STEP_W){1'b0}}, step_i};
      wrap_o = sum[PTR_W];
   end

   // load has priority over a same-cycle increment
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (ld_en_i)  ptr_q <= ld_data_i;
      else if (inc_en_i) ptr_q <= sum[PTR_W-1:0];
   end

   assign ptr_o = ptr_q;

   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i |=> ptr_q == $past(ld_data_i));

   p_step_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en_i && !ld_en_i |=> PTR_W'(ptr_q - $past(ptr_q)) == PTR_W'($past(step_i)));

   p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_en_i && !ld_en_i |=> $stable(ptr_q));
endmodule

// File: rtl/bmag_bank_regs.sv
module bmag_bank_regs #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ld_en_i,
   input  logic [BANK_W-1:0] ld_data_i,
   output logic [BANK_W-1:0] cur_bank_o,
   output logic [BANK_W-1:0] ext_bank_o
);
   logic [1:0][BANK_W-1:0] bank_q;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bank_q[b] <= '0;
         else if (ld_en_i[b]) bank_q[b] <= ld_data_i;
      end

      p_bank_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
         ld_en_i[b] |=> bank_q[b] == $past(ld_data_i));
      p_bank_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !ld_en_i[b] |=> $stable(bank_q[b]));
   end

   assign cur_bank_o = bank_q[0];
   assign ext_bank_o = bank_q[1];
endmodule

// File: rtl/bmag_addr_mux.sv
module bmag_addr_mux
   import bmag_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter int PTR_W  = 8,
   localparam int ADDR_W = BANK_W + PTR_W
) (
   input  logic [1:0]        mode_i,
   input  logic              bank_sel_i,
   input  logic              ptr_sel_i,
   input  logic [ADDR_W-1:0] imm_i,
   input  logic [BANK_W-1:0] cur_bank_i,
   input  logic [BANK_W-1:0] ext_bank_i,
   input  logic [PTR_W-1:0]  pri_ptr_i,
   input  logic [PTR_W-1:0]  sec_ptr_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [BANK_W-1:0] ind_bank;
   logic [PTR_W-1:0]  ind_ptr;

   always_comb begin
      ind_bank = bank_sel_i ? ext_bank_i : cur_bank_i;
      ind_ptr  = ptr_sel_i  ? sec_ptr_i  : pri_ptr_i;
      case (amode_e'(mode_i))
         AM_DIRECT:  addr_o = imm_i;
         AM_BOTPAGE: addr_o = {{BANK_W{1'b0}}, imm_i[PTR_W-1:0]};
         AM_CURBANK: addr_o = {cur_bank_i, imm_i[PTR_W-1:0]};
         default:    addr_o = {ind_bank, ind_ptr};
      endcase
   end
endmodule

// File: rtl/bank_nibble_agen.sv
module bank_nibble_agen
   import bmag_pkg::*;
#(
   parameter int BANK_W      = 4,
   parameter int NIB_W       = 4,
   parameter int WIDE_STEP   = 2,
   localparam int PTR_W      = 2 * NIB_W,
   localparam int ADDR_W     = BANK_W + PTR_W,
   localparam int STEP_W     = $clog2(WIDE_STEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              ptr_sel_i,
   input  logic              bank_sel_i,
   input  logic              post_inc_i,
   input  logic              wide_i,
   input  logic [ADDR_W-1:0] imm_i,
   input  logic              op_done_i,
   input  logic              inc_req_i,
   input  logic              ld_ptr_i,
   input  logic              ld_ptr_sel_i,
   input  logic [PTR_W-1:0]  ld_ptr_data_i,
   input  logic              ld_cur_bank_i,
   input  logic              ld_ext_bank_i,
   input  logic [BANK_W-1:0] ld_bank_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [PTR_W-1:0]  pri_ptr_o,
   output logic [PTR_W-1:0]  sec_ptr_o,
   output logic [BANK_W-1:0] cur_bank_o,
   output logic [BANK_W-1:0] ext_bank_o,
   output logic              g_flag_o
);
   localparam logic [PTR_W-1:0] SAFE_LIM = PTR_W'((1 << PTR_W) - WIDE_STEP);

   if (BANK_W < 1 || NIB_W < 1) begin : g_bad_width
      $error("bank and nibble widths must be positive");
   end
   if (WIDE_STEP < 1 || WIDE_STEP >= (1 << PTR_W)) begin : g_bad_wide
      $error("wide step must lie between 1 and the pointer range");
   end

   logic                   post_evt, inc_evt, tgt_loaded, g_q;
   logic [STEP_W-1:0]      step;
   logic [1:0]             pair_inc, pair_ld, pair_wrap;
   logic [1:0][PTR_W-1:0]  pair_q;
   logic [PTR_W-1:0]       tgt_ptr;

   always_comb begin
      post_evt   = op_done_i && post_inc_i && (amode_e'(mode_i) == AM_INDIRECT);
      inc_evt    = post_evt || inc_req_i;
      step       = (post_evt && wide_i) ? STEP_W'(WIDE_STEP) : STEP_W'(1);
      tgt_loaded = pair_ld[ptr_sel_i];
      tgt_ptr    = pair_q[ptr_sel_i];
   end

   for (genvar p = 0; p < 2; p++) begin : g_pair
      assign pair_inc[p] = inc_evt && (ptr_sel_i == 1'(p));
      assign pair_ld[p]  = ld_ptr_i && (ld_ptr_sel_i == 1'(p));

      bmag_ptr_pair #(.PTR_W(PTR_W), .STEP_W(STEP_W)) u_pair (
         .clk       (clk),
         .rst_n     (rst_n),
         .inc_en_i  (pair_inc[p]),
         .step_i    (step),
         .ld_en_i   (pair_ld[p]),
         .ld_data_i (ld_ptr_data_i),
         .ptr_o     (pair_q[p]),
         .wrap_o    (pair_wrap[p])
      );
   end

   bmag_bank_regs #(.BANK_W(BANK_W)) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en_i    ({ld_ext_bank_i, ld_cur_bank_i}),
      .ld_data_i  (ld_bank_data_i),
      .cur_bank_o (cur_bank_o),
      .ext_bank_o (ext_bank_o)
   );

   bmag_addr_mux #(.BANK_W(BANK_W), .PTR_W(PTR_W)) u_mux (
      .mode_i     (mode_i),
      .bank_sel_i (bank_sel_i),
      .ptr_sel_i  (ptr_sel_i),
      .imm_i      (imm_i),
      .cur_bank_i (cur_bank_o),
      .ext_bank_i (ext_bank_o),
      .pri_ptr_i  (pair_q[0]),
      .sec_ptr_i  (pair_q[1]),
      .addr_o     (addr_o)
   );

   // G follows every increment that is not overridden by a load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      g_q <= 1'b0;
      else if (inc_evt && !tgt_loaded) g_q <= pair_wrap[ptr_sel_i];
   end

   assign pri_ptr_o = pair_q[0];
   assign sec_ptr_o = pair_q[1];
   assign g_flag_o  = g_q;

   p_botpage_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      amode_e'(mode_i) == AM_BOTPAGE |-> addr_o[ADDR_W-1:PTR_W] == '0);

   p_curbank_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
      amode_e'(mode_i) == AM_CURBANK |-> addr_o[ADDR_W-1:PTR_W] == cur_bank_o);

   p_g_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inc_evt && !tgt_loaded && (&tgt_ptr) |=> g_q);

   p_g_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inc_evt && !tgt_loaded && (tgt_ptr < SAFE_LIM) |=> !g_q);

   p_g_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_evt || tgt_loaded) |=> $stable(g_q));
endmodule

// File: tb/bank_nibble_agen_tb.sv
module bank_nibble_agen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = '0;
   logic        ptr_sel_i = 0, bank_sel_i = 0, post_inc_i = 0, wide_i = 0;
   logic [11:0] imm_i = '0;
   logic        op_done_i = 0, inc_req_i = 0, ld_ptr_i = 0, ld_ptr_sel_i = 0;
   logic [7:0]  ld_ptr_data_i = '0;
   logic        ld_cur_bank_i = 0, ld_ext_bank_i = 0;
   logic [3:0]  ld_bank_data_i = '0;
   logic [11:0] addr_o;
   logic [7:0]  pri_ptr_o, sec_ptr_o;
   logic [3:0]  cur_bank_o, ext_bank_o;
   logic        g_flag_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_nibble_agen dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ptr_sel_i(ptr_sel_i),
      .bank_sel_i(bank_sel_i), .post_inc_i(post_inc_i), .wide_i(wide_i),
      .imm_i(imm_i), .op_done_i(op_done_i), .inc_req_i(inc_req_i),
      .ld_ptr_i(ld_ptr_i), .ld_ptr_sel_i(ld_ptr_sel_i), .ld_ptr_data_i(ld_ptr_data_i),
      .ld_cur_bank_i(ld_cur_bank_i), .ld_ext_bank_i(ld_ext_bank_i),
      .ld_bank_data_i(ld_bank_data_i), .addr_o(addr_o), .pri_ptr_o(pri_ptr_o),
      .sec_ptr_o(sec_ptr_o), .cur_bank_o(cur_bank_o), .ext_bank_o(ext_bank_o),
      .g_flag_o(g_flag_o));

   typedef struct {
      string       tag;
      int          sel;
      logic [11:0] exp;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    checks = 0, errors = 0;
   bit    finished = 0;

   logic [7:0] m_pri, m_sec;
   logic [3:0] m_cur, m_ext;
   logic       m_g;

   function automatic logic [11:0] actual(int sel);
      case (sel)
         0: return addr_o;
         1: return {4'h0, pri_ptr_o};
         2: return {4'h0, sec_ptr_o};
         3: return {8'h0, cur_bank_o};
         4: return {8'h0, ext_bank_o};
         default: return {11'h0, g_flag_o};
      endcase
   endfunction

   // monitor: pops expected items and compares with the outputs
   initial forever begin
      @(mon_ev);
      while (q.size() > 0) begin
         item_t it;
         logic [11:0] act;
         it  = q.pop_front();
         act = actual(it.sel);
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s output#%0d: actual %h expected %h", it.tag, it.sel, act, it.exp);
         end
      end
   end

   task automatic push(string tag, int sel, logic [11:0] exp);
      item_t it;
      it.tag = tag; it.sel = sel; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic drain();
      -> mon_ev;
      #1;
   endtask

   task automatic push_state(string tag);
      push(tag, 1, {4'h0, m_pri});
      push(tag, 2, {4'h0, m_sec});
      push(tag, 3, {8'h0, m_cur});
      push(tag, 4, {8'h0, m_ext});
      push(tag, 5, {11'h0, m_g});
   endtask

   function automatic logic [11:0] model_addr(logic [1:0] md, logic ps, logic bs, logic [11:0] im);
      case (md)
         2'd0: return im;
         2'd1: return {4'h0, im[7:0]};
         2'd2: return {m_cur, im[7:0]};
         default: return {(bs ? m_ext : m_cur), (ps ? m_sec : m_pri)};
      endcase
   endfunction

   // driver: one cycle of stimulus, expected address now, expected state after the edge
   task automatic run(string tag, logic [1:0] md, logic ps, logic bs, logic pinc, logic wd,
                      logic [11:0] im, logic opd, logic inc, logic ldp, logic ldps,
                      logic [7:0] ldd, logic ldc, logic lde, logic [3:0] bd);
      logic       pev, iev, hit;
      logic [8:0] sum;
      @(negedge clk);
      mode_i = md; ptr_sel_i = ps; bank_sel_i = bs; post_inc_i = pinc; wide_i = wd;
      imm_i = im; op_done_i = opd; inc_req_i = inc; ld_ptr_i = ldp; ld_ptr_sel_i = ldps;
      ld_ptr_data_i = ldd; ld_cur_bank_i = ldc; ld_ext_bank_i = lde; ld_bank_data_i = bd;
      #1;
      push(tag, 0, model_addr(md, ps, bs, im));
      drain();
      pev = opd && pinc && (md == 2'd3);
      iev = pev || inc;
      hit = ldp && (ldps == ps);
      sum = {1'b0, (ps ? m_sec : m_pri)} + ((pev && wd) ? 9'd2 : 9'd1);
      if (iev && !hit) begin
         if (ps) m_sec = sum[7:0]; else m_pri = sum[7:0];
         m_g = sum[8];
      end
      if (ldp) begin
         if (ldps) m_sec = ldd; else m_pri = ldd;
      end
      if (ldc) m_cur = bd;
      if (lde) m_ext = bd;
      @(posedge clk);
      @(negedge clk);
      #1;
      push_state(tag);
      drain();
      mode_i = '0; post_inc_i = 0; op_done_i = 0; inc_req_i = 0;
      ld_ptr_i = 0; ld_cur_bank_i = 0; ld_ext_bank_i = 0;
   endtask

   task automatic ldptr(string tag, logic sel, logic [7:0] v);
      run(tag, 2'd0, 0, 0, 0, 0, 12'h0, 0, 0, 1, sel, v, 0, 0, 4'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_pri = '0; m_sec = '0; m_cur = '0; m_ext = '0; m_g = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      push_state("R1 reset");
      drain();

      // R2 full direct
      run("R2 direct", 2'd0, 0, 0, 0, 0, 12'hA5C, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R2 direct", 2'd0, 1, 1, 0, 0, 12'h3FF, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      // R11 bank loads
      run("R11 cur bank", 2'd0, 0, 0, 0, 0, 12'h000, 0, 0, 0, 0, 8'h0, 1, 0, 4'h3);
      run("R11 ext bank", 2'd0, 0, 0, 0, 0, 12'h000, 0, 0, 0, 0, 8'h0, 0, 1, 4'hC);
      // R3 and R4
      run("R3 bottom page", 2'd1, 0, 0, 0, 0, 12'hB7E, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R4 current bank", 2'd2, 0, 0, 0, 0, 12'h9D2, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      // R5 indirect combinations
      ldptr("R5 load pri", 0, 8'h12);
      ldptr("R5 load sec", 1, 8'hF0);
      run("R5 cur+pri", 2'd3, 0, 0, 0, 0, 12'h0, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R5 ext+sec", 2'd3, 1, 1, 0, 0, 12'h0, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R5 cur+sec", 2'd3, 1, 0, 0, 0, 12'h0, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R5 ext+pri", 2'd3, 0, 1, 0, 0, 12'h0, 0, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      // R6 and R7 post-increment
      run("R6 step one", 2'd3, 0, 0, 1, 0, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R6 step two", 2'd3, 0, 1, 1, 1, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      ldptr("R7 load FF", 1, 8'hFF);
      run("R7 wrap one", 2'd3, 1, 0, 1, 0, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      ldptr("R7 load FE", 1, 8'hFE);
      run("R7 wrap two", 2'd3, 1, 1, 1, 1, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      ldptr("R7 load FF", 1, 8'hFF);
      run("R7 wrap two odd", 2'd3, 1, 0, 1, 1, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R7 clear", 2'd3, 1, 0, 1, 0, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      // R9 strobes that must not step
      ldptr("R9 load FF", 0, 8'hFF);
      run("R8 set G", 2'd0, 0, 0, 0, 0, 12'h0, 0, 1, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R9 no post-inc", 2'd3, 0, 0, 0, 1, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      run("R9 not indirect", 2'd2, 0, 0, 1, 0, 12'h455, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);
      // R8 increment request
      ldptr("R8 load 10", 1, 8'h10);
      run("R8 inc sec", 2'd1, 1, 0, 0, 0, 12'h021, 0, 1, 0, 0, 8'h0, 0, 0, 4'h0);
      ldptr("R8 load FF", 0, 8'hFF);
      run("R8 inc wrap", 2'd0, 0, 0, 0, 0, 12'h0, 0, 1, 0, 0, 8'h0, 0, 0, 4'h0);
      // R10 load beats increment, G held
      run("R10 collide", 2'd3, 0, 0, 1, 1, 12'h0, 1, 0, 1, 0, 8'h40, 0, 0, 4'h0);
      run("R10 other pair", 2'd3, 1, 0, 1, 0, 12'h0, 1, 0, 1, 0, 8'h77, 0, 0, 4'h0);
      // R6 sweep of two-steps through several wraps
      for (int i = 0; i < 300; i++)
         run("R6 sweep", 2'd3, 1, 1, 1, 1, 12'h0, 1, 0, 0, 0, 8'h0, 0, 0, 4'h0);

      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule